// File: doc/BRIEF.md
# Reset and HALT Wake-up Controller

This block decides when a small microcontroller core is held in reset, when it sleeps and when it runs again. It watches a power-on indication, an active-low external reset pin and a watchdog overflow pulse. It also watches the HALT and CLR-WDT instruction strobes, the port A pins with a per-pin wake enable, and the interrupt request, interrupt enable and stack-full information. From these it drives a full chip reset or a warm reset, where the warm reset clears only the program counter and stack pointer. It also drives an execute enable and the start-up timer busy line. The cause of the last reset or wake is held in a register, together with the two status flags TO (timeout) and PDF (power-down).

The controller is one state machine. ST_SST waits for the start-up timer and is the state after power-on. ST_RUN is normal execution. ST_HALT is sleep. ST_PIN_RUN and ST_PIN_HALT hold reset while the pin is low, one for a pin pulled while running and one for a pin pulled while halted. ST_WDT_RST is a one-cycle reset after a watchdog overflow in run. ST_IRQ_GAP is the extra cycle before a vectored interrupt.

The transitions are as follows:
- SST→RUN when the timer expires.
- SST→IRQ_GAP when the timer expires and a vectored interrupt is pending.
- RUN→HALT on the HALT strobe.
- RUN→WDT_RST on a watchdog overflow.
- WDT_RST→RUN after one cycle.
- Any state except HALT and PIN_HALT goes to PIN_RUN while the pin is low.
- PIN_RUN→RUN when the pin is released, with no start-up delay.
- HALT→PIN_HALT while the pin is low.
- PIN_HALT→SST when the pin is released.
- HALT→SST on a watchdog overflow, an enabled port edge or a new interrupt request.
- IRQ_GAP→RUN after one cycle.

A pin reset during ST_SST cuts the start-up wait short.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: While `por_i` is high: `chip_rst_o`=1, `sst_busy_o`=1, `exec_en_o`=0, TO=0, PDF=0 and `wake_cause_o`=0. After release, `sst_busy_o` and `chip_rst_o` stay high for exactly SST_CYCLES (1024) clock samples, counting the one at release, and then `exec_en_o` rises.
- R2: A low pin in run holds `chip_rst_o` high and `exec_en_o` low. `exec_en_o` returns the cycle after release with no start-up wait. TO and PDF keep their values and `wake_cause_o`=1.
- R3: A watchdog overflow in run gives exactly one cycle of `chip_rst_o`, sets TO, leaves PDF unchanged and sets `wake_cause_o`=3.
- R4: A HALT strobe in run sets `halted_o` and PDF the next cycle. A CLR-WDT strobe in run clears PDF.
- R5: A watchdog overflow in halt starts a 1024-cycle start-up wait. During the wait `warm_rst_o` is high and `chip_rst_o` is low. TO=1, PDF=1 and `wake_cause_o`=4.
- R6: A low pin in halt asserts `chip_rst_o` and sets TO=0, PDF=1 and `wake_cause_o`=2. After release, a 1024-cycle start-up wait follows with `chip_rst_o` held high.
- R7: In halt, a falling edge on a port A pin whose enable bit is set wakes the device after a two-flop synchronizer, with `wake_cause_o`=5. An edge on a pin whose enable bit is clear, or an edge that happened during run, does not wake it.
- R8: A request bit that rises in halt wakes the device with `wake_cause_o`=6. A request bit already set when HALT executed cannot wake it.
- R9: After an interrupt wake, `irq_vec_o`=1 only if a waking request is enabled and the stack is not full. A vectored wake keeps `exec_en_o` low for one extra cycle after the start-up wait.
- R10: In halt the priority is pin, then watchdog, then port edge, then interrupt. In run the pin takes priority over the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on indication, active high, asynchronous |
| rst_pin_n | input | 1 | External reset pin, active low |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| halt_i | input | 1 | HALT instruction strobe |
| clr_wdt_i | input | 1 | CLR-WDT instruction strobe |
| pa_pin_i | input | PA_W | Port A pin levels |
| pa_wake_en_i | input | PA_W | Per-pin wake enable |
| irq_req_i | input | IRQ_W | Interrupt request flags |
| irq_en_i | input | IRQ_W | Interrupt enables |
| stack_full_i | input | 1 | Stack has no free entry |
| chip_rst_o | output | 1 | Full chip reset |
| warm_rst_o | output | 1 | Reset of program counter and stack pointer only |
| sst_busy_o | output | 1 | Start-up timer running |
| exec_en_o | output | 1 | Core may execute |
| halted_o | output | 1 | Device is in HALT |
| wake_cause_o | output | 3 | Last reset/wake cause: 0 power, 1 pin-run, 2 pin-halt, 3 watchdog-run, 4 watchdog-halt, 5 port, 6 interrupt |
| irq_vec_o | output | 1 | Last interrupt wake requests a vectored response |
| to_flag_o | output | 1 | TO status flag |
| pdf_flag_o | output | 1 | PDF status flag |

## Verification
The hardest case is a set of events that compete in the same cycle while the device is halted. To reach it, the bench first puts the core in HALT with one request already pending and with port edges on a pin that cannot wake it. It then raises the pin reset, a watchdog pulse and a new interrupt together on one falling clock edge, so the priority decides the single cycle in which the state changes. The vectored-interrupt gap cycle can only be seen at the end of a full 1024-cycle wait. For that reason the bench counts every busy cycle and samples `exec_en_o` at the first cycle after the wait.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

    typedef enum logic [2:0] {
        ST_SST,
        ST_RUN,
        ST_HALT,
        ST_PIN_RUN,
        ST_PIN_HALT,
        ST_WDT_RST,
        ST_IRQ_GAP
    } pw_state_e;

    typedef enum logic [2:0] {
        WC_POWER    = 3'd0,
        WC_PIN_RUN  = 3'd1,
        WC_PIN_HALT = 3'd2,
        WC_WDT_RUN  = 3'd3,
        WC_WDT_HALT = 3'd4,
        WC_PORT     = 3'd5,
        WC_IRQ      = 3'd6
    } wake_cause_e;

endpackage

// File: rtl/pa_wake_detect.sv
module pa_wake_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         por_i,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] en_i,
    output logic         hit_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;
    logic [W-1:0] fall;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            meta_q <= '1;
            sync_q <= '1;
            prev_q <= '1;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign fall[b] = prev_q[b] & ~sync_q[b] & en_i[b];
    end

    assign hit_o = |fall;

endmodule

// File: rtl/sst_timer.sv
module sst_timer #(
    parameter int CYCLES = 1024
) (
    input  logic clk,
    input  logic por_i,
    input  logic load_i,
    output logic last_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i)
            cnt_q <= CW'(CYCLES);
        else if (load_i)
            cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last_o = (cnt_q == CW'(1));

    // R1: the wait advances by exactly one every cycle it is not reloaded
    assert_count_down_R1: assert property (@(posedge clk) disable iff (por_i)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/reset_flags.sv
module reset_flags (
    input  logic clk,
    input  logic por_i,
    input  logic set_to_i,
    input  logic clr_to_i,
    input  logic set_pdf_i,
    input  logic clr_pdf_i,
    output logic to_o,
    output logic pdf_o
);
    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            to_o  <= 1'b0;
            pdf_o <= 1'b0;
        end else begin
            if (set_to_i)
                to_o <= 1'b1;
            else if (clr_to_i)
                to_o <= 1'b0;
            if (set_pdf_i)
                pdf_o <= 1'b1;
            else if (clr_pdf_i)
                pdf_o <= 1'b0;
        end
    end

endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
    import pwr_wake_pkg::*;
#(
    parameter int PA_W       = 8,
    parameter int IRQ_W      = 4,
    parameter int SST_CYCLES = 1024
) (
    input  logic             clk,
    input  logic             por_i,
    input  logic             rst_pin_n,
    input  logic             wdt_ovf_i,
    input  logic             halt_i,
    input  logic             clr_wdt_i,
    input  logic [PA_W-1:0]  pa_pin_i,
    input  logic [PA_W-1:0]  pa_wake_en_i,
    input  logic [IRQ_W-1:0] irq_req_i,
    input  logic [IRQ_W-1:0] irq_en_i,
    input  logic             stack_full_i,
    output logic             chip_rst_o,
    output logic             warm_rst_o,
    output logic             sst_busy_o,
    output logic             exec_en_o,
    output logic             halted_o,
    output logic [2:0]       wake_cause_o,
    output logic             irq_vec_o,
    output logic             to_flag_o,
    output logic             pdf_flag_o
);
    pw_state_e   state_q, state_d;
    wake_cause_e cause_q, cause_d;
    logic        vec_q, vec_d;
    logic [IRQ_W-1:0] snap_q, snap_d;

    logic set_to, clr_to, set_pdf, clr_pdf;
    logic pa_hit, sst_last, sst_load;
    logic [IRQ_W-1:0] irq_new;
    logic irq_wake, irq_vec_ok;

    pa_wake_detect #(.W(PA_W)) u_pa (
        .clk   (clk),
        .por_i (por_i),
        .pin_i (pa_pin_i),
        .en_i  (pa_wake_en_i),
        .hit_o (pa_hit)
    );

    sst_timer #(.CYCLES(SST_CYCLES)) u_sst (
        .clk    (clk),
        .por_i  (por_i),
        .load_i (sst_load),
        .last_o (sst_last)
    );

    reset_flags u_flags (
        .clk       (clk),
        .por_i     (por_i),
        .set_to_i  (set_to),
        .clr_to_i  (clr_to),
        .set_pdf_i (set_pdf),
        .clr_pdf_i (clr_pdf),
        .to_o      (to_flag_o),
        .pdf_o     (pdf_flag_o)
    );

    assign irq_new    = irq_req_i & ~snap_q;
    assign irq_wake   = |irq_new;
    assign irq_vec_ok = (|(irq_new & irq_en_i)) & ~stack_full_i;
    assign sst_load   = (state_d == ST_SST) && (state_q != ST_SST);

    // State register
    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            state_q <= ST_SST;
            cause_q <= WC_POWER;
            vec_q   <= 1'b0;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            vec_q   <= vec_d;
            snap_q  <= snap_d;
        end
    end

    // Next state and flag updates
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        vec_d   = vec_q;
        snap_d  = snap_q;
        set_to  = 1'b0;
        clr_to  = 1'b0;
        set_pdf = 1'b0;
        clr_pdf = 1'b0;
        unique case (state_q)
            ST_SST: begin
                if (!rst_pin_n) begin
                    state_d = ST_PIN_RUN;
                    cause_d = WC_PIN_RUN;
                    vec_d   = 1'b0;
                end else if (sst_last) begin
                    state_d = (cause_q == WC_IRQ && vec_q) ? ST_IRQ_GAP : ST_RUN;
                end
            end
            ST_RUN: begin
                if (!rst_pin_n) begin
                    state_d = ST_PIN_RUN;
                    cause_d = WC_PIN_RUN;
                    vec_d   = 1'b0;
                end else if (wdt_ovf_i) begin
                    state_d = ST_WDT_RST;
                    cause_d = WC_WDT_RUN;
                    vec_d   = 1'b0;
                    set_to  = 1'b1;
                end else if (halt_i) begin
                    state_d = ST_HALT;
                    snap_d  = irq_req_i;
                    set_pdf = 1'b1;
                end else if (clr_wdt_i) begin
                    clr_pdf = 1'b1;
                end
            end
            ST_WDT_RST, ST_IRQ_GAP: begin
                if (!rst_pin_n) begin
                    state_d = ST_PIN_RUN;
                    cause_d = WC_PIN_RUN;
                    vec_d   = 1'b0;
                end else begin
                    state_d = ST_RUN;
                end
            end
            ST_PIN_RUN: begin
                if (rst_pin_n)
                    state_d = ST_RUN;
            end
            ST_PIN_HALT: begin
                if (rst_pin_n)
                    state_d = ST_SST;
            end
            ST_HALT: begin
                if (!rst_pin_n) begin
                    state_d = ST_PIN_HALT;
                    cause_d = WC_PIN_HALT;
                    vec_d   = 1'b0;
                    clr_to  = 1'b1;
                    set_pdf = 1'b1;
                end else if (wdt_ovf_i) begin
                    state_d = ST_SST;
                    cause_d = WC_WDT_HALT;
                    vec_d   = 1'b0;
                    set_to  = 1'b1;
                    set_pdf = 1'b1;
                end else if (pa_hit) begin
                    state_d = ST_SST;
                    cause_d = WC_PORT;
                    vec_d   = 1'b0;
                end else if (irq_wake) begin
                    state_d = ST_SST;
                    cause_d = WC_IRQ;
                    vec_d   = irq_vec_ok;
                end
            end
            default: state_d = ST_SST;
        endcase
    end

    // Outputs
    always_comb begin
        chip_rst_o = 1'b0;
        warm_rst_o = 1'b0;
        sst_busy_o = 1'b0;
        exec_en_o  = 1'b0;
        halted_o   = 1'b0;
        unique case (state_q)
            ST_SST: begin
                sst_busy_o = 1'b1;
                chip_rst_o = (cause_q == WC_POWER) || (cause_q == WC_PIN_HALT);
                warm_rst_o = (cause_q == WC_WDT_HALT);
            end
            ST_RUN:                              exec_en_o  = 1'b1;
            ST_HALT:                             halted_o   = 1'b1;
            ST_PIN_RUN, ST_PIN_HALT, ST_WDT_RST: chip_rst_o = 1'b1;
            ST_IRQ_GAP:                          exec_en_o  = 1'b0;
            default:                             chip_rst_o = 1'b1;
        endcase
    end

    assign wake_cause_o = cause_q;
    assign irq_vec_o    = vec_q;

    // R4: HALT entry is visible on the flag register
    assert_halt_sets_pdf_R4: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_RUN && rst_pin_n && !wdt_ovf_i && halt_i) |=> (halted_o && pdf_flag_o));

    // R2: a pin reset while running leaves both flags alone
    assert_pin_run_keeps_flags_R2: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_RUN && !rst_pin_n) |=> (chip_rst_o && $stable(to_flag_o) && $stable(pdf_flag_o)));

    // R2: release of a running pin reset skips the start-up wait
    assert_pin_skips_sst_R2: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_PIN_RUN && rst_pin_n) |=> (exec_en_o && !sst_busy_o));

    // R5: watchdog wake from halt is a warm reset with both flags set
    assert_wdt_halt_warm_R5: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_HALT && rst_pin_n && wdt_ovf_i) |=> (warm_rst_o && !chip_rst_o && to_flag_o && pdf_flag_o));

    // R9: a vectored wake spends one more cycle before execution
    assert_vec_gap_R9: assert property (@(posedge clk) disable iff (por_i)
        ($fell(sst_busy_o) && irq_vec_o && !chip_rst_o) |-> !exec_en_o);

endmodule

// File: tb/pwr_wake_ctrl_tb.sv
module pwr_wake_ctrl_tb;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       pin_n = 1'b1;
    logic       wdt = 1'b0;
    logic       halt = 1'b0;
    logic       clrw = 1'b0;
    logic [7:0] pa = 8'hFF;
    logic [7:0] pa_en = 8'h04;
    logic [3:0] ireq = 4'h0;
    logic [3:0] ien = 4'h0;
    logic       sfull = 1'b0;

    logic       chip_rst, warm_rst, sst_busy, exec_en, halted, ivec, to_f, pdf_f;
    logic [2:0] cause;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    pwr_wake_ctrl u_dut (
        .clk          (clk),
        .por_i        (por),
        .rst_pin_n    (pin_n),
        .wdt_ovf_i    (wdt),
        .halt_i       (halt),
        .clr_wdt_i    (clrw),
        .pa_pin_i     (pa),
        .pa_wake_en_i (pa_en),
        .irq_req_i    (ireq),
        .irq_en_i     (ien),
        .stack_full_i (sfull),
        .chip_rst_o   (chip_rst),
        .warm_rst_o   (warm_rst),
        .sst_busy_o   (sst_busy),
        .exec_en_o    (exec_en),
        .halted_o     (halted),
        .wake_cause_o (cause),
        .irq_vec_o    (ivec),
        .to_flag_o    (to_f),
        .pdf_flag_o   (pdf_f)
    );

    typedef struct packed {
        logic [1:0] kind;   // 0 watchdog, 1 port edge, 2 interrupt
        logic [3:0] en;
        logic       full;
        logic [2:0] cause;
        logic       vec;
        logic       to;
    } wake_vec_t;

    localparam wake_vec_t TBL [5] = '{
        '{2'd0, 4'h0, 1'b0, 3'd4, 1'b0, 1'b1},
        '{2'd1, 4'h0, 1'b0, 3'd5, 1'b0, 1'b1},
        '{2'd2, 4'h2, 1'b0, 3'd6, 1'b1, 1'b1},
        '{2'd2, 4'h0, 1'b0, 3'd6, 1'b0, 1'b1},
        '{2'd2, 4'h2, 1'b1, 3'd6, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Counts busy samples from the current one; also counts samples with each reset low
    task automatic count_sst(output int n, output int rst_lo, output int warm_lo);
        n = 0; rst_lo = 0; warm_lo = 0;
        while (sst_busy && n < 3000) begin
            n++;
            if (!chip_rst) rst_lo++;
            if (!warm_rst) warm_lo++;
            @(negedge clk);
        end
    endtask

    task automatic halt_pulse();
        @(negedge clk) halt = 1'b1;
        @(negedge clk) halt = 1'b0;
    endtask

    task automatic run_vec(input wake_vec_t v, input int idx);
        int n, rl, wl;
        string tag;
        tag = (v.kind == 2'd0) ? "R5" : (v.kind == 2'd1) ? "R7" : "R8";
        ien = v.en; sfull = v.full;
        halt_pulse();
        chk("R4", $sformatf("vec%0d halted after strobe", idx), halted, 1);
        chk("R4", $sformatf("vec%0d PDF after strobe", idx), pdf_f, 1);
        repeat (3) @(negedge clk);
        unique case (v.kind)
            2'd0: begin wdt = 1'b1; @(negedge clk) wdt = 1'b0; end
            2'd1: pa[2] = 1'b0;
            default: ireq[1] = 1'b1;
        endcase
        for (int i = 0; i < 10 && halted; i++) @(negedge clk);
        chk(tag, $sformatf("vec%0d wake cause", idx), cause, v.cause);
        chk(tag, $sformatf("vec%0d start-up busy", idx), sst_busy, 1);
        count_sst(n, rl, wl);
        chk(tag, $sformatf("vec%0d start-up length", idx), n, 1024);
        if (v.kind == 2'd0) begin
            chk("R5", "warm reset held through wait", wl, 0);
            chk("R5", "no full reset during warm wait", rl, 1024);
        end
        if (v.vec) begin
            chk("R9", $sformatf("vec%0d gap cycle exec_en", idx), exec_en, 0);
            @(negedge clk);
        end
        chk("R9", $sformatf("vec%0d exec_en after wait", idx), exec_en, 1);
        chk("R9", $sformatf("vec%0d vector request", idx), ivec, v.vec);
        chk(tag, $sformatf("vec%0d TO", idx), to_f, v.to);
        pa = 8'hFF; ireq = 4'h0; ien = 4'h0; sfull = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int n, rl, wl;
        // R1: power-on state and start-up wait
        repeat (3) @(negedge clk);
        chk("R1", "chip_rst in power-on", chip_rst, 1);
        chk("R1", "busy in power-on", sst_busy, 1);
        chk("R1", "exec_en in power-on", exec_en, 0);
        chk("R1", "TO in power-on", to_f, 0);
        chk("R1", "PDF in power-on", pdf_f, 0);
        chk("R1", "cause in power-on", cause, 0);
        por = 1'b0;
        count_sst(n, rl, wl);
        chk("R1", "start-up length after power-on", n, 1024);
        chk("R1", "chip_rst held during wait", rl, 0);
        chk("R1", "exec_en after wait", exec_en, 1);

        for (int k = 0; k < 5; k++) run_vec(TBL[k], k);

        // R4: CLR-WDT clears PDF
        @(negedge clk) clrw = 1'b1;
        @(negedge clk) clrw = 1'b0;
        chk("R4", "PDF after CLR-WDT", pdf_f, 0);

        // R2: pin reset while running
        @(negedge clk) pin_n = 1'b0;
        @(negedge clk);
        chk("R2", "chip_rst with pin low", chip_rst, 1);
        chk("R2", "exec_en with pin low", exec_en, 0);
        repeat (2) @(negedge clk);
        pin_n = 1'b1;
        @(negedge clk);
        chk("R2", "exec_en after release", exec_en, 1);
        chk("R2", "no start-up wait", sst_busy, 0);
        chk("R2", "TO unchanged", to_f, 1);
        chk("R2", "PDF unchanged", pdf_f, 0);
        chk("R2", "cause pin-run", cause, 1);

        // R3: watchdog while running
        @(negedge clk) wdt = 1'b1;
        @(negedge clk) wdt = 1'b0;
        chk("R3", "chip_rst pulse", chip_rst, 1);
        chk("R3", "cause watchdog-run", cause, 3);
        chk("R3", "TO set", to_f, 1);
        chk("R3", "PDF unchanged", pdf_f, 0);
        @(negedge clk);
        chk("R3", "reset lasts one cycle", chip_rst, 0);
        chk("R3", "exec resumes", exec_en, 1);

        // R7, R8: ignored wake sources
        pa[2] = 1'b0;
        ireq[0] = 1'b1;
        repeat (5) @(negedge clk);
        halt_pulse();
        repeat (12) @(negedge clk);
        chk("R7", "edge from run does not wake", halted, 1);
        chk("R8", "pending request does not wake", halted, 1);
        pa[5] = 1'b0;
        repeat (8) @(negedge clk);
        chk("R7", "disabled pin edge does not wake", halted, 1);

        // R10, R6: pin, watchdog and interrupt together in halt
        ien = 4'h2;
        pin_n = 1'b0; wdt = 1'b1; ireq[1] = 1'b1;
        @(negedge clk) wdt = 1'b0;
        chk("R10", "pin wins in halt", cause, 2);
        chk("R6", "chip_rst with pin in halt", chip_rst, 1);
        chk("R6", "TO cleared", to_f, 0);
        chk("R6", "PDF set", pdf_f, 1);
        repeat (2) @(negedge clk);
        pin_n = 1'b1; pa = 8'hFF; ireq = 4'h0; ien = 4'h0;
        @(negedge clk);
        count_sst(n, rl, wl);
        chk("R6", "start-up length after halt pin reset", n, 1024);
        chk("R6", "chip_rst held during wait", rl, 0);
        chk("R6", "exec after wait", exec_en, 1);

        // R10: watchdog beats interrupt in halt
        ien = 4'h2;
        halt_pulse();
        repeat (2) @(negedge clk);
        wdt = 1'b1; ireq[1] = 1'b1;
        @(negedge clk) wdt = 1'b0;
        chk("R10", "watchdog wins over interrupt", cause, 4);
        chk("R10", "no vector on watchdog wake", ivec, 0);
        count_sst(n, rl, wl);
        ireq = 4'h0; ien = 4'h0;
        @(negedge clk);

        // R10: pin beats watchdog in run
        pin_n = 1'b0; wdt = 1'b1;
        @(negedge clk) wdt = 1'b0;
        chk("R10", "pin wins over watchdog in run", cause, 1);
        chk("R10", "TO unchanged", to_f, 1);
        @(negedge clk) pin_n = 1'b1;
        @(negedge clk);
        chk("R2", "running after release", exec_en, 1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule